// File: doc/BRIEF.md
# ATA Task-File Command Register Block

This block is the device-side register file of a parallel ATA disk that supports only DMA transfers. A host writes byte registers over a simple register bus: a sector count, three LBA bytes, a device/head byte and a command byte. When a DMA command is accepted, the block latches a 24-bit LBA and a sector count and presents them, with a transfer direction and a byte length, as a job descriptor. It then holds a request toward a bus-master engine until the engine takes the job.

The engine moves the data and pulses a completion input, together with a flag saying whether it reports an interrupt. The block then clears BSY, sets DRDY and raises its interrupt line. A host read of the status register has a side effect: it drops the pending interrupt. A second status address reads the same byte without that side effect. Opcodes other than the two DMA commands fail at once with ERR and an interrupt, and no job is started.

Top module: `tf_cmd_block`

## Requirements
- R1: After reset the status byte reads 0x40 (DRDY only), irq and job_req are low, and the count, LBA and device registers read 0.
- R2: Register map: 0 = sector count, 1 = LBA bits 7:0, 2 = LBA bits 15:8, 3 = LBA bits 23:16, 4 = device/head. Each register reads back what was written, and job_lba is {byte3, byte2, byte1}.
- R3: A write to address 5 (command) with opcode 0xC8 or 0xCA is accepted when the device byte has bit 6 set (LBA mode) and bit 4 clear (device 0). On the next cycle the status reads 0x80 (BSY set, DRDY clear), job_req is high, and job_dir is 1 for 0xC8 (disk to memory) and 0 for 0xCA.
- R4: job_sectors equals the count register, or 256 when the count is 0, and job_bytes equals job_sectors × 512. The descriptor stays stable while job_req is high.
- R5: job_req stays high until a cycle in which job_ack is high, and is low on the following cycle.
- R6: A xfer_done pulse after the job was taken clears BSY and sets DRDY, so the status reads 0x40 with DF (bit 5), DRQ (bit 3) and ERR (bit 0) clear. irq rises if xfer_intr is high with the pulse. A xfer_done pulse before the job is taken has no effect.
- R7: Any other opcode, or a DMA opcode with device bit 6 clear, sets the status to 0x41 (DRDY and ERR) and raises irq on the next cycle, with no job request.
- R8: A command write while device bit 4 is set is ignored: status, irq and job_req do not change.
- R9: A read of address 5 clears irq on the next cycle. A read of address 6 returns the same status byte and leaves irq unchanged. A completion in the same cycle as a status read leaves irq set.
- R10: While BSY is set, writes to any register, including the command register, are ignored.
- R11: An accepted DMA command clears ERR and any pending irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (matters for the side effect of a status read) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| job_req | output | 1 | DMA job request toward the bus-master engine |
| job_ack | input | 1 | Engine has taken the job |
| job_dir | output | 1 | 1 = disk to memory, 0 = memory to disk |
| job_lba | output | 8*LBA_BYTES | Starting LBA |
| job_sectors | output | 9 | Sector count, 1 to 256 |
| job_bytes | output | 9+SECT_SHIFT | Transfer length in bytes |
| xfer_done | input | 1 | Engine completion pulse |
| xfer_intr | input | 1 | Engine reports an interrupt with the completion |
| irq | output | 1 | Interrupt request line |

## Verification
The assertions assume that the host does not assert reg_wr and reg_rd in the same cycle. They also assume that the engine pulses xfer_done only while a job is in its hands. The bench drives one strobe at a time from tasks to respect the first point. It breaks the second point only once, on purpose, to show that an early completion is ignored, and no property depends on that case. The sweeps run through every opcode and every sector count against arithmetically derived status bytes and descriptors.

// File: rtl/tf_pkg.sv
package tf_pkg;

  localparam logic [7:0] OPC_DMA_IN  = 8'hC8;
  localparam logic [7:0] OPC_DMA_OUT = 8'hCA;

  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DF   = 5;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  localparam int DEV_LBA_BIT = 6;
  localparam int DEV_SEL_BIT = 4;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_RUN  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_IGNORE = 2'd0,
    CMD_START  = 2'd1,
    CMD_ABORT  = 2'd2
  } cmd_kind_e;

endpackage

// File: rtl/tf_regbank.sv
module tf_regbank #(
  parameter int LBA_BYTES = 3,
  parameter int ADDR_W    = 3,
  localparam int LBA_W    = 8 * LBA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              lock,
  output logic [7:0]        cnt_q,
  output logic [LBA_W-1:0]  lba_q,
  output logic [7:0]        dev_q
);

  localparam int CNT_ADDR = 0;
  localparam int DEV_ADDR = LBA_BYTES + 1;

  logic       wr_ok;
  logic       cnt_we;
  logic       dev_we;
  logic [7:0] cnt_d;
  logic [7:0] dev_d;

  assign wr_ok  = wr_en && !lock;
  assign cnt_we = wr_ok && (wr_addr == ADDR_W'(CNT_ADDR));
  assign dev_we = wr_ok && (wr_addr == ADDR_W'(DEV_ADDR));

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we) cnt_d = wr_data;
  end

  always_comb begin
    dev_d = dev_q;
    if (dev_we) dev_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dev_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      dev_q <= dev_d;
    end
  end

  for (genvar g = 0; g < LBA_BYTES; g++) begin : g_lba
    logic       byte_we;
    logic [7:0] byte_d;

    assign byte_we = wr_ok && (wr_addr == ADDR_W'(g + 1));

    always_comb begin
      byte_d = lba_q[8*g +: 8];
      if (byte_we) byte_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lba_q[8*g +: 8] <= '0;
      else        lba_q[8*g +: 8] <= byte_d;
    end
  end

endmodule

// File: rtl/tf_cmd_decode.sv
module tf_cmd_decode #(
  parameter int SECT_SHIFT = 9,
  localparam int CNT_W     = 8,
  localparam int SECT_W    = CNT_W + 1,
  localparam int BYTE_W    = SECT_W + SECT_SHIFT
) (
  input  logic [7:0]          opcode,
  input  logic [7:0]          dev,
  input  logic [CNT_W-1:0]    cnt,
  output tf_pkg::cmd_kind_e   kind,
  output logic                dir_in,
  output logic [SECT_W-1:0]   sectors,
  output logic [BYTE_W-1:0]   bytes
);
  import tf_pkg::*;

  logic is_dma;

  assign is_dma = (opcode == OPC_DMA_IN) || (opcode == OPC_DMA_OUT);
  assign dir_in = (opcode == OPC_DMA_IN);

  always_comb begin
    if (dev[DEV_SEL_BIT])                kind = CMD_IGNORE;
    else if (is_dma && dev[DEV_LBA_BIT]) kind = CMD_START;
    else                                 kind = CMD_ABORT;
  end

  always_comb begin
    if (cnt == '0) sectors = SECT_W'(1 << CNT_W);
    else           sectors = {1'b0, cnt};
  end

  assign bytes = BYTE_W'(sectors) << SECT_SHIFT;

endmodule

// File: rtl/tf_seq.sv
module tf_seq #(
  parameter int LBA_W  = 24,
  parameter int SECT_W = 9,
  parameter int BYTE_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              stat_rd,
  input  tf_pkg::cmd_kind_e kind,
  input  logic              dir_in,
  input  logic [LBA_W-1:0]  lba,
  input  logic [SECT_W-1:0] sectors,
  input  logic [BYTE_W-1:0] bytes,
  input  logic              job_ack,
  input  logic              xfer_done,
  input  logic              xfer_intr,
  output logic              busy,
  output logic              drdy,
  output logic              err,
  output logic              irq,
  output logic              job_req,
  output logic              job_dir,
  output logic [LBA_W-1:0]  job_lba,
  output logic [SECT_W-1:0] job_sectors,
  output logic [BYTE_W-1:0] job_bytes
);
  import tf_pkg::*;

  seq_state_e state_q, state_d;
  logic       drdy_q, drdy_d;
  logic       err_q, err_d;
  logic       irq_q, irq_d;
  logic       load;

  always_comb begin
    state_d = state_q;
    drdy_d  = drdy_q;
    err_d   = err_q;
    irq_d   = irq_q & ~stat_rd;
    load    = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (cmd_wr) begin
          unique case (kind)
            CMD_START: begin
              state_d = SQ_REQ;
              drdy_d  = 1'b0;
              err_d   = 1'b0;
              irq_d   = 1'b0;
              load    = 1'b1;
            end
            CMD_ABORT: begin
              drdy_d = 1'b1;
              err_d  = 1'b1;
              irq_d  = 1'b1;
            end
            default: ;
          endcase
        end
      end
      SQ_REQ: begin
        if (job_ack) state_d = SQ_RUN;
      end
      SQ_RUN: begin
        if (xfer_done) begin
          state_d = SQ_IDLE;
          drdy_d  = 1'b1;
          if (xfer_intr) irq_d = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      drdy_q  <= 1'b1;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      drdy_q  <= drdy_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job_dir     <= 1'b0;
      job_lba     <= '0;
      job_sectors <= '0;
      job_bytes   <= '0;
    end else if (load) begin
      job_dir     <= dir_in;
      job_lba     <= lba;
      job_sectors <= sectors;
      job_bytes   <= bytes;
    end
  end

  assign busy    = (state_q != SQ_IDLE);
  assign job_req = (state_q == SQ_REQ);
  assign drdy    = drdy_q;
  assign err     = err_q;
  assign irq     = irq_q;

endmodule

// File: rtl/tf_cmd_block.sv
module tf_cmd_block #(
  parameter int LBA_BYTES  = 3,
  parameter int SECT_SHIFT = 9,
  parameter int ADDR_W     = 3,
  localparam int LBA_W     = 8 * LBA_BYTES,
  localparam int SECT_W    = 9,
  localparam int BYTE_W    = SECT_W + SECT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              job_req,
  input  logic              job_ack,
  output logic              job_dir,
  output logic [LBA_W-1:0]  job_lba,
  output logic [SECT_W-1:0] job_sectors,
  output logic [BYTE_W-1:0] job_bytes,
  input  logic              xfer_done,
  input  logic              xfer_intr,
  output logic              irq
);
  import tf_pkg::*;

  localparam int CNT_ADDR  = 0;
  localparam int DEV_ADDR  = LBA_BYTES + 1;
  localparam int CMD_ADDR  = LBA_BYTES + 2;
  localparam int ALT_ADDR  = LBA_BYTES + 3;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [7:0]        cnt_q;
  logic [LBA_W-1:0]  lba_q;
  logic [7:0]        dev_q;
  logic              busy;
  logic              drdy;
  logic              err;
  logic              cmd_wr;
  logic              stat_rd;
  cmd_kind_e         kind;
  logic              dir_in;
  logic [SECT_W-1:0] sectors;
  logic [BYTE_W-1:0] bytes;
  logic [7:0]        stat_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign cmd_wr  = reg_wr && (reg_addr == ADDR_W'(CMD_ADDR));
  assign stat_rd = reg_rd && (reg_addr == ADDR_W'(CMD_ADDR));

  tf_regbank #(
    .LBA_BYTES (LBA_BYTES),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .lock    (busy),
    .cnt_q   (cnt_q),
    .lba_q   (lba_q),
    .dev_q   (dev_q)
  );

  tf_cmd_decode #(
    .SECT_SHIFT (SECT_SHIFT)
  ) u_dec (
    .opcode  (reg_wdata),
    .dev     (dev_q),
    .cnt     (cnt_q),
    .kind    (kind),
    .dir_in  (dir_in),
    .sectors (sectors),
    .bytes   (bytes)
  );

  tf_seq #(
    .LBA_W  (LBA_W),
    .SECT_W (SECT_W),
    .BYTE_W (BYTE_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cmd_wr      (cmd_wr),
    .stat_rd     (stat_rd),
    .kind        (kind),
    .dir_in      (dir_in),
    .lba         (lba_q),
    .sectors     (sectors),
    .bytes       (bytes),
    .job_ack     (job_ack),
    .xfer_done   (xfer_done),
    .xfer_intr   (xfer_intr),
    .busy        (busy),
    .drdy        (drdy),
    .err         (err),
    .irq         (irq),
    .job_req     (job_req),
    .job_dir     (job_dir),
    .job_lba     (job_lba),
    .job_sectors (job_sectors),
    .job_bytes   (job_bytes)
  );

  always_comb begin
    stat_byte          = '0;
    stat_byte[ST_BSY]  = busy;
    stat_byte[ST_DRDY] = drdy;
    stat_byte[ST_DF]   = 1'b0;
    stat_byte[ST_DRQ]  = 1'b0;
    stat_byte[ST_ERR]  = err;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CNT_ADDR)) reg_rdata = cnt_q;
    for (int i = 0; i < LBA_BYTES; i++) begin
      if (reg_addr == ADDR_W'(i + 1)) reg_rdata = lba_q[8*i +: 8];
    end
    if (reg_addr == ADDR_W'(DEV_ADDR)) reg_rdata = dev_q;
    if (reg_addr == ADDR_W'(CMD_ADDR) || reg_addr == ADDR_W'(ALT_ADDR))
      reg_rdata = stat_byte;
  end

endmodule

// File: rtl/tf_cmd_block_chk.sv
module tf_cmd_block_chk #(
  parameter int LBA_W      = 24,
  parameter int SECT_W     = 9,
  parameter int BYTE_W     = 18,
  parameter int SECT_SHIFT = 9,
  parameter int ADDR_W     = 3,
  parameter int STAT_ADDR  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              job_req,
  input logic              job_ack,
  input logic              job_dir,
  input logic [LBA_W-1:0]  job_lba,
  input logic [SECT_W-1:0] job_sectors,
  input logic [BYTE_W-1:0] job_bytes,
  input logic              xfer_done,
  input logic              irq,
  input logic [7:0]        stat_byte
);

  p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    job_req |-> (stat_byte[7] && !stat_byte[6]));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (job_req && !job_ack) |=> job_req);

  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (job_req && job_ack) |=> !job_req);

  p_desc_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (job_req && !job_ack) |=> ($stable(job_lba) && $stable(job_sectors) && $stable(job_dir)));

  p_desc_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    job_req |-> (job_sectors != '0 && job_sectors <= SECT_W'(256) &&
                 job_bytes == (BYTE_W'(job_sectors) << SECT_SHIFT)));

  p_stat_rd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == ADDR_W'(STAT_ADDR) && !xfer_done) |=> !irq);

  p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[0] |-> !stat_byte[7]);

  p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !stat_byte[7]);

  p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[7] && !job_req && xfer_done) |=> (!stat_byte[7] && stat_byte[6]));

  p_flags_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_byte[7] && $fell(stat_byte[7])) |-> (stat_byte[6] && !stat_byte[0]));

endmodule

bind tf_cmd_block tf_cmd_block_chk #(
  .LBA_W      (LBA_W),
  .SECT_W     (SECT_W),
  .BYTE_W     (BYTE_W),
  .SECT_SHIFT (SECT_SHIFT),
  .ADDR_W     (ADDR_W),
  .STAT_ADDR  (CMD_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .job_req     (job_req),
  .job_ack     (job_ack),
  .job_dir     (job_dir),
  .job_lba     (job_lba),
  .job_sectors (job_sectors),
  .job_bytes   (job_bytes),
  .xfer_done   (xfer_done),
  .irq         (irq),
  .stat_byte   (stat_byte)
);

// File: tb/tf_cmd_block_tb.sv
module tf_cmd_block_tb;

  localparam logic [2:0] A_CNT = 3'd0;
  localparam logic [2:0] A_LO  = 3'd1;
  localparam logic [2:0] A_MID = 3'd2;
  localparam logic [2:0] A_HI  = 3'd3;
  localparam logic [2:0] A_DEV = 3'd4;
  localparam logic [2:0] A_CMD = 3'd5;
  localparam logic [2:0] A_ALT = 3'd6;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_rd;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        job_req;
  logic        job_ack;
  logic        job_dir;
  logic [23:0] job_lba;
  logic [8:0]  job_sectors;
  logic [17:0] job_bytes;
  logic        xfer_done;
  logic        xfer_intr;
  logic        irq;

  int checks;
  int failures;

  tf_cmd_block u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .job_req     (job_req),
    .job_ack     (job_ack),
    .job_dir     (job_dir),
    .job_lba     (job_lba),
    .job_sectors (job_sectors),
    .job_bytes   (job_bytes),
    .xfer_done   (xfer_done),
    .xfer_intr   (xfer_intr),
    .irq         (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ack_job();
    @(negedge clk); job_ack = 1'b1;
    @(negedge clk); job_ack = 1'b0;
  endtask

  task automatic finish_job(input logic intr);
    @(negedge clk); xfer_done = 1'b1; xfer_intr = intr;
    @(negedge clk); xfer_done = 1'b0; xfer_intr = 1'b0;
  endtask

  task automatic load_regs(input logic [7:0] cnt, input logic [23:0] lba, input logic [7:0] dev);
    wr(A_CNT, cnt);
    wr(A_LO, lba[7:0]);
    wr(A_MID, lba[15:8]);
    wr(A_HI, lba[23:16]);
    wr(A_DEV, dev);
  endtask

  task automatic run_good(input logic [7:0] op, input logic [7:0] cnt, input logic [23:0] lba);
    logic [7:0] d;
    int exp_sect;
    exp_sect = (cnt == 8'd0) ? 256 : int'(cnt);
    load_regs(cnt, lba, 8'h40);
    wr(A_CMD, op);
    rd(A_ALT, d);
    chk("R3 busy status", d, 8'h80);
    chk("R3 job_req", job_req, 1);
    chk("R3 job_dir", job_dir, (op == 8'hC8) ? 1 : 0);
    chk("R2 job_lba", job_lba, lba);
    chk("R4 job_sectors", job_sectors, exp_sect);
    chk("R4 job_bytes", job_bytes, exp_sect * 512);
    ack_job();
    chk("R5 req dropped", job_req, 0);
    finish_job(1'b1);
    chk("R6 irq after done", irq, 1);
    rd(A_ALT, d);
    chk("R6 done status", d, 8'h40);
    chk("R9 alt keeps irq", irq, 1);
    rd(A_CMD, d);
    chk("R6 status read", d, 8'h40);
    chk("R9 status read clears irq", irq, 0);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    repeat (60000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    job_ack = 1'b0; xfer_done = 1'b0; xfer_intr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 job_req", job_req, 0);
    rd(A_ALT, d); chk("R1 status", d, 8'h40);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); chk("R1 reg zero", d, 0);
    end

    // R2 readback
    load_regs(8'h12, 24'hA5C381, 8'h4F);
    rd(A_CNT, d); chk("R2 count", d, 8'h12);
    rd(A_LO, d);  chk("R2 lba low", d, 8'h81);
    rd(A_MID, d); chk("R2 lba mid", d, 8'hC3);
    rd(A_HI, d);  chk("R2 lba high", d, 8'hA5);
    rd(A_DEV, d); chk("R2 device", d, 8'h4F);

    // R4 sweep of every sector count
    for (int c = 0; c < 256; c++) begin
      run_good((c % 2 == 0) ? 8'hC8 : 8'hCA, 8'(c), 24'((c * 65793) ^ 24'h5A3C0F));
    end

    // R7 sweep of every opcode
    for (int op = 0; op < 256; op++) begin
      if (op == 8'hC8 || op == 8'hCA) begin
        run_good(8'(op), 8'd1, 24'(op));
      end else begin
        wr(A_DEV, 8'h40);
        wr(A_CMD, 8'(op));
        rd(A_ALT, d);
        chk("R7 abort status", d, 8'h41);
        chk("R7 abort irq", irq, 1);
        chk("R7 no job", job_req, 0);
        rd(A_CMD, d);
        chk("R9 clear after abort", irq, 0);
      end
    end

    // R7 DMA opcode without LBA mode
    wr(A_DEV, 8'h00);
    wr(A_CMD, 8'hC8);
    rd(A_ALT, d);
    chk("R7 chs abort status", d, 8'h41);
    chk("R7 chs abort no job", job_req, 0);

    // R8 device 1 selected: ignored, abort state kept
    wr(A_DEV, 8'h50);
    wr(A_CMD, 8'hCA);
    rd(A_ALT, d);
    chk("R8 status unchanged", d, 8'h41);
    chk("R8 irq unchanged", irq, 1);
    chk("R8 no job", job_req, 0);

    // R11 accepted command clears ERR and irq
    wr(A_DEV, 8'h40);
    wr(A_CMD, 8'hCA);
    rd(A_ALT, d);
    chk("R11 err cleared", d, 8'h80);
    chk("R11 irq cleared", irq, 0);

    // R10 writes ignored while busy
    wr(A_CNT, 8'h33);
    rd(A_CNT, d); chk("R10 count locked", d, 8'h01);
    wr(A_CMD, 8'h00);
    rd(A_ALT, d); chk("R10 command ignored", d, 8'h80);
    chk("R10 no irq", irq, 0);

    // R6 early completion ignored
    finish_job(1'b1);
    rd(A_ALT, d); chk("R6 early done ignored", d, 8'h80);
    chk("R6 req still held", job_req, 1);
    ack_job();
    finish_job(1'b0);
    rd(A_ALT, d); chk("R6 done no intr status", d, 8'h40);
    chk("R6 no intr no irq", irq, 0);

    // R9 completion and status read in the same cycle
    load_regs(8'd2, 24'h000100, 8'h40);
    wr(A_CMD, 8'hC8);
    ack_job();
    @(negedge clk);
    xfer_done = 1'b1; xfer_intr = 1'b1; reg_rd = 1'b1; reg_addr = A_CMD;
    @(negedge clk);
    xfer_done = 1'b0; xfer_intr = 1'b0; reg_rd = 1'b0;
    chk("R9 completion wins", irq, 1);
    rd(A_CMD, d);
    chk("R9 later read clears", irq, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule